// File: doc/BRIEF.md
# Trace Capture Controller

This block records processor trace events into a 64-line on-chip buffer whose lines are 8 bytes wide. A mode input selects one of two formats. The compact format records program flow: every change-of-flow strobe produces a 4-byte entry holding a control byte and the 24-bit program counter, and two such entries share one line. The detail format records data accesses: every strobe produces one full line holding a control byte, the 24-bit access address and up to two data bytes, which are steered by access size and by the low address bit.

An entry counter tracks how far the buffer has filled. Its upper bits give the line being written. In compact mode its lowest bit counts single entries, while in detail mode that bit stays at zero and the upper bits advance once per line. The counter wraps after twice the line count. A half-filled compact line waits in a staging register and is written out when the second entry arrives or when capture is disarmed. Software arms the block, clears it with a synchronous clear, and reads lines back through an indexed port that answers one cycle after each request.

Top module: `dbg_trace_capture`

## Requirements
- R1: In compact mode (`detail_mode`=0), only an armed strobe with `cap_cof`=1 creates an entry. An entry is {info, pc[23:16], pc[15:8], pc[7:0]}. The even-numbered entry lands in line bits 31:0, the odd one in bits 63:32, and the line index is `entry_cnt[6:1]`.
- R2: In compact mode each recorded entry increments `entry_cnt` by 1.
- R3: In detail mode (`detail_mode`=1), every armed strobe is recorded regardless of `cap_cof`. `entry_cnt` then advances by 2 and its bit 0 is zero.
- R4: A detail line is {info, addr[23:16], addr[15:8], addr[7:0], byte3, byte2, 8'h00, 8'h00}, with byte 7 in bits 63:56.
- R5: A detail byte access (`cap_word`=0) stores its byte in line byte 2 and zeroes byte 3. The byte comes from `cap_data[15:8]` when `cap_a0`=0 and from `cap_data[7:0]` when `cap_a0`=1.
- R6: A detail word access (`cap_word`=1) stores `cap_data[15:8]` (the lower-address byte) in line byte 3 and `cap_data[7:0]` in byte 2.
- R7: When `arm` falls while `entry_cnt[0]`=1, the held half line is written to its line with bits 63:32 zero.
- R8: While `arm`=0, strobes change neither the counter nor the buffer.
- R9: `clr`=1 sets `entry_cnt` to 0 and `data_vld` to 0 on the next edge and overrides any strobe in that cycle.
- R10: `data_vld` becomes 1 on the edge that records an entry.
- R11: `rd_req`=1 returns line `rd_idx` on `rd_line` with `rd_vld`=1 one cycle later; without a request, `rd_vld` is 0.
- R12: `entry_cnt` wraps modulo 128, so 64 detail entries return it to 0 and the next entry rewrites line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Capture enable (level) |
| clr | input | 1 | Synchronous clear of counter and flag |
| detail_mode | input | 1 | 0 compact program flow, 1 detail data access |
| cap_vld | input | 1 | Capture strobe |
| cap_cof | input | 1 | Strobe is a change of flow |
| cap_pc | input | 24 | Program counter |
| cap_info | input | 8 | Control/info byte |
| cap_addr | input | 24 | Access address |
| cap_data | input | 16 | Access data, lower-address byte in 15:8 |
| cap_word | input | 1 | 1 word access, 0 byte access |
| cap_a0 | input | 1 | Low address bit of a byte access |
| rd_req | input | 1 | Line read request |
| rd_idx | input | 6 | Line to read |
| rd_line | output | 64 | Line read data |
| rd_vld | output | 1 | Read data valid |
| entry_cnt | output | 7 | Entry counter |
| data_vld | output | 1 | Buffer holds at least one entry |

## Verification
Some rules can be checked on every cycle, and the assertions cover them: how far the counter steps in each mode, that bit 0 stays clear after a detail entry, that the counter stays put while disarmed, the effect of clear, the setting of the valid flag, and the one-cycle read handshake. Other behaviour only shows up through whole scenarios, so the bench exercises it: the byte layout of compact and detail lines, lane steering for byte and word accesses, the zero-padded flush of a half line on disarm, a buffer left unchanged by ignored strobes, and the wrap that rewrites line 0.

// File: rtl/trc_pkg.sv
// Shared formats for the trace capture controller.
// Assumes fixed field widths: 24-bit PC/address, 8-bit info, 16-bit data.
package trc_pkg;
    localparam int ENTRY_W = 32;
    localparam int LINE_W  = 2 * ENTRY_W;

    typedef logic [ENTRY_W-1:0] trc_entry_t;
    typedef logic [LINE_W-1:0]  trc_line_t;

    // Compact entry: info byte above the three program counter bytes.
    function automatic trc_entry_t make_flow_entry(input logic [7:0] info,
                                                   input logic [23:0] pc);
        return {info, pc};
    endfunction

    // Detail line: info, address, two steered data bytes, two zero bytes.
    function automatic trc_line_t make_access_line(input logic [7:0] info,
                                                   input logic [23:0] addr,
                                                   input logic [15:0] data,
                                                   input logic is_word,
                                                   input logic a0);
        logic [7:0] b3;
        logic [7:0] b2;
        if (is_word) begin
            b3 = data[15:8];
            b2 = data[7:0];
        end else begin
            b3 = 8'h00;
            b2 = a0 ? data[7:0] : data[15:8];
        end
        return {info, addr, b3, b2, 16'h0000};
    endfunction
endpackage

// File: rtl/trc_entry_counter.sv
// Entry counter. Compact entries add one; detail entries advance the
// upper bits and force bit 0 low. Wraps at 2**CNT_W. Clear has priority.
module trc_entry_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rec,
    input  logic             detail,
    output logic [CNT_W-1:0] cnt
);
    // Counter update per recorded entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (rec) begin
            if (detail) cnt <= {cnt[CNT_W-1:1] + 1'b1, 1'b0};
            else        cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/trc_line_builder.sv
// Forms the line to write. Detail entries give a full line at once; compact
// entries pair up through a staging register. A flush writes the staged
// half with a zero upper half. Assumes the mode changes only while disarmed.
module trc_line_builder
    import trc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        rec,
    input  logic        detail,
    input  logic        flush,
    input  logic        odd_slot,
    input  logic [7:0]  info,
    input  logic [23:0] pc,
    input  logic [23:0] addr,
    input  logic [15:0] data,
    input  logic        is_word,
    input  logic        a0,
    output logic        wr_en,
    output trc_line_t   wr_line
);
    trc_entry_t stage_q;
    trc_entry_t flow_entry;

    // Build the compact entry from the current strobe.
    always_comb flow_entry = make_flow_entry(info, pc);

    // Select the write source for this cycle.
    always_comb begin
        wr_en   = 1'b0;
        wr_line = '0;
        if (rec && detail) begin
            wr_en   = 1'b1;
            wr_line = make_access_line(info, addr, data, is_word, a0);
        end else if (rec && odd_slot) begin
            wr_en   = 1'b1;
            wr_line = {flow_entry, stage_q};
        end else if (flush) begin
            wr_en   = 1'b1;
            wr_line = {{ENTRY_W{1'b0}}, stage_q};
        end
    end

    // Hold the first compact entry of a line.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stage_q <= '0;
        end else if (rec && !detail && !odd_slot) begin
            stage_q <= flow_entry;
        end
    end
endmodule

// File: rtl/trc_line_ram.sv
// Line storage with one write port and a registered read port.
// A read of a line written in the same cycle returns the old contents.
module trc_line_ram #(
    parameter int DEPTH  = 64,
    parameter int LINE_W = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    output logic [LINE_W-1:0] rd_data,
    output logic              rd_vld
);
    logic [LINE_W-1:0] mem [DEPTH];

    // Store a line.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Return the requested line one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd_req;
            if (rd_req) rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/dbg_trace_capture.sv
// Trace capture controller top. Qualifies strobes, derives the flush on
// disarm, keeps the valid flag and ties counter, builder and storage.
// Assumes detail_mode is stable while armed.
module dbg_trace_capture #(
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH),
    localparam int CNT_W  = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             clr,
    input  logic             detail_mode,
    input  logic             cap_vld,
    input  logic             cap_cof,
    input  logic [23:0]      cap_pc,
    input  logic [7:0]       cap_info,
    input  logic [23:0]      cap_addr,
    input  logic [15:0]      cap_data,
    input  logic             cap_word,
    input  logic             cap_a0,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_idx,
    output logic [63:0]      rd_line,
    output logic             rd_vld,
    output logic [CNT_W-1:0] entry_cnt,
    output logic             data_vld
);
    import trc_pkg::*;

    logic      arm_q;
    logic      rec;
    logic      flush;
    logic      wr_en;
    trc_line_t wr_line;

    // Qualify a strobe into a recorded entry.
    always_comb rec = arm && !clr && cap_vld && (cap_cof || detail_mode);

    // Flush a staged half line when capture is switched off.
    always_comb flush = arm_q && !arm && !clr && entry_cnt[0];

    // Track arm for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm;
    end

    // Valid flag: set by any entry, cleared by clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) data_vld <= 1'b0;
        else if (rec)      data_vld <= 1'b1;
    end

    trc_entry_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .rec    (rec),
        .detail (detail_mode),
        .cnt    (entry_cnt)
    );

    trc_line_builder u_build (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .rec      (rec),
        .detail   (detail_mode),
        .flush    (flush),
        .odd_slot (entry_cnt[0]),
        .info     (cap_info),
        .pc       (cap_pc),
        .addr     (cap_addr),
        .data     (cap_data),
        .is_word  (cap_word),
        .a0       (cap_a0),
        .wr_en    (wr_en),
        .wr_line  (wr_line)
    );

    trc_line_ram #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (entry_cnt[CNT_W-1:1]),
        .wr_data (wr_line),
        .rd_req  (rd_req),
        .rd_addr (rd_idx),
        .rd_data (rd_line),
        .rd_vld  (rd_vld)
    );
endmodule

// File: rtl/trc_capture_checker.sv
// Cycle rules of the trace capture controller, bound to its top.
module trc_capture_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             clr,
    input logic             detail_mode,
    input logic             cap_vld,
    input logic             cap_cof,
    input logic             rd_req,
    input logic             rd_vld,
    input logic [CNT_W-1:0] entry_cnt,
    input logic             data_vld
);
    logic take;
    always_comb take = arm && !clr && cap_vld && (cap_cof || detail_mode);

    assert_flow_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !detail_mode) |=> entry_cnt == $past(entry_cnt) + 1'b1);

    assert_detail_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && detail_mode) |=>
            entry_cnt == {$past(entry_cnt[CNT_W-1:1]) + 1'b1, 1'b0});

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !clr) |=> $stable(entry_cnt));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (entry_cnt == '0 && !data_vld));

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> data_vld);

    assert_read_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_vld);

    assert_read_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_vld);
endmodule

bind dbg_trace_capture trc_capture_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .clr         (clr),
    .detail_mode (detail_mode),
    .cap_vld     (cap_vld),
    .cap_cof     (cap_cof),
    .rd_req      (rd_req),
    .rd_vld      (rd_vld),
    .entry_cnt   (entry_cnt),
    .data_vld    (data_vld)
);

// File: tb/tb_dbg_trace_capture.sv
module tb_dbg_trace_capture;
    typedef struct {
        logic [63:0] line;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        clr = 1'b0;
    logic        detail_mode = 1'b0;
    logic        cap_vld = 1'b0;
    logic        cap_cof = 1'b0;
    logic [23:0] cap_pc = '0;
    logic [7:0]  cap_info = '0;
    logic [23:0] cap_addr = '0;
    logic [15:0] cap_data = '0;
    logic        cap_word = 1'b0;
    logic        cap_a0 = 1'b0;
    logic        rd_req = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_line;
    logic        rd_vld;
    logic [6:0]  entry_cnt;
    logic        data_vld;

    int checks = 0;
    int failures = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    dbg_trace_capture dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one strobe for one cycle.
    task automatic strobe(input logic cof, input logic [7:0] info, input logic [23:0] pc,
                          input logic [23:0] addr, input logic [15:0] data,
                          input logic word, input logic a0);
        @(negedge clk);
        cap_vld = 1'b1; cap_cof = cof; cap_info = info; cap_pc = pc;
        cap_addr = addr; cap_data = data; cap_word = word; cap_a0 = a0;
        @(negedge clk);
        cap_vld = 1'b0;
    endtask

    // Driver: request a line and push its expected value.
    task automatic read_line(input logic [5:0] idx, input logic [63:0] exp, input string tag);
        @(negedge clk);
        sb.push_back('{line: exp, tag: tag});
        rd_req = 1'b1; rd_idx = idx;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // Monitor: compare each returned line with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_vld) begin
            if (sb.size() == 0) begin
                chk("R11 unexpected read data", 64'h1, 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, rd_line, e.line);
            end
        end
    end

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset count", {57'h0, entry_cnt}, 64'h0);
        chk("R10 reset flag", {63'h0, data_vld}, 64'h0);
        chk("R11 reset rd_vld", {63'h0, rd_vld}, 64'h0);

        // Compact mode.
        arm = 1'b1;
        strobe(1'b0, 8'h99, 24'h999999, 24'h0, 16'h0, 1'b0, 1'b0);
        chk("R1 non-flow strobe ignored", {57'h0, entry_cnt}, 64'h0);
        strobe(1'b1, 8'h11, 24'h123456, 24'h0, 16'h0, 1'b0, 1'b0);
        chk("R2 count after first", {57'h0, entry_cnt}, 64'd1);
        chk("R10 flag set", {63'h0, data_vld}, 64'h1);
        strobe(1'b1, 8'h22, 24'hA1B2C3, 24'h0, 16'h0, 1'b0, 1'b0);
        chk("R2 count after second", {57'h0, entry_cnt}, 64'd2);
        read_line(6'd0, 64'h22A1B2C3_11123456, "R1 compact line pair");
        strobe(1'b1, 8'h33, 24'h0F0E0D, 24'h0, 16'h0, 1'b0, 1'b0);
        chk("R2 count odd", {57'h0, entry_cnt}, 64'd3);

        // Disarm flushes the half line.
        @(negedge clk); arm = 1'b0;
        @(negedge clk);
        read_line(6'd1, 64'h00000000_330F0E0D, "R7 flush half line");
        strobe(1'b1, 8'h77, 24'h777777, 24'h0, 16'h0, 1'b0, 1'b0);
        chk("R8 count held while disarmed", {57'h0, entry_cnt}, 64'd3);
        read_line(6'd1, 64'h00000000_330F0E0D, "R8 buffer unchanged while disarmed");

        // Clear, with a strobe in the same cycle.
        @(negedge clk); clr = 1'b1; arm = 1'b1;
        cap_vld = 1'b1; cap_cof = 1'b1;
        @(negedge clk); clr = 1'b0; cap_vld = 1'b0; arm = 1'b0;
        chk("R9 clear count", {57'h0, entry_cnt}, 64'h0);
        chk("R9 clear flag", {63'h0, data_vld}, 64'h0);

        // Detail mode.
        @(negedge clk); detail_mode = 1'b1; arm = 1'b1;
        strobe(1'b0, 8'h44, 24'h0, 24'hABCDEF, 16'h1234, 1'b1, 1'b0);
        chk("R3 detail step", {57'h0, entry_cnt}, 64'd2);
        read_line(6'd0, 64'h44ABCDEF_12340000, "R4 R6 detail word line");
        strobe(1'b0, 8'h45, 24'h0, 24'h102030, 16'h5678, 1'b0, 1'b0);
        read_line(6'd1, 64'h45102030_00560000, "R5 byte lane a0=0");
        strobe(1'b1, 8'h46, 24'h0, 24'h102031, 16'h5678, 1'b0, 1'b1);
        read_line(6'd2, 64'h46102031_00780000, "R5 byte lane a0=1");
        chk("R3 detail count bit0 low", {57'h0, entry_cnt}, 64'd6);

        // Wrap.
        @(negedge clk); arm = 1'b0;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; arm = 1'b1;
        for (int i = 0; i < 64; i++)
            strobe(1'b0, 8'h55, 24'h0, 24'(i), 16'hBEEF, 1'b1, 1'b0);
        chk("R12 wrap to zero", {57'h0, entry_cnt}, 64'h0);
        read_line(6'd63, 64'h5500003F_BEEF0000, "R12 last line before wrap");
        strobe(1'b0, 8'h56, 24'h0, 24'h000100, 16'hCAFE, 1'b1, 1'b0);
        read_line(6'd0, 64'h56000100_CAFE0000, "R12 line 0 rewritten");
        chk("R12 count after wrap", {57'h0, entry_cnt}, 64'd2);

        repeat (3) @(negedge clk);
        chk("R11 all reads answered", 64'(sb.size()), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule